// File: doc/BRIEF.md
# Zero-Cross Comparator Blanking Qualifier

This block conditions the digital outputs of several back-EMF comparators before control logic uses them. Each raw comparator bit is asynchronous to the system clock, so it first passes through a two-flop synchronizer. A per-channel polarity bit then makes each channel active high or active low. The adjusted level of every channel is visible in real time. One channel, or none, is routed to a registered position output.

A one-cycle trigger, normally taken from a PWM switching edge, opens a blanking window. The window hides the switching noise that follows a commutation. Its length comes from a fixed, non-linear 4-bit code, expressed in nanoseconds and converted to system clocks using a clock-period parameter. While the window is open, the position output keeps its value and comparator edges are discarded.

Outside the window, a rising or falling edge on an enabled channel sets a sticky flag. Software clears a flag by writing 1 to it. A hold input freezes the position output for as long as it is set.

Top module: `zc_blank_qual`

## Requirements
- R1: `chan_stat[i]` equals `cmp_raw[i]` XOR `pol_inv[i]`, so a polarity bit of 1 means active low. It follows a change on `cmp_raw` two clock edges later, through the synchronizer.
- R2: `pos_out` is registered and updates one edge after `chan_stat`. The `pos_sel` encoding is: 2'b00 drives 0 (not connected), 2'b01 selects channel 0, 2'b10 selects channel 1 and 2'b11 selects channel 2.
- R3: While `pos_hold` is 1, `pos_out` keeps its value. The first edge after `pos_hold` returns to 0 loads the currently selected level.
- R4: When `blank_trig` is 1 at an edge and `blank_mode` is not 2'b00, a window of ceil(T/CLK_NS) cycles starts. T is selected by `blank_code`: 0:100, 1:250, 2:500, 3:750, 4:1000, 5:1250, 6:1500, 7:2000, 8:2500, 9:3000, 10:3500, 11:4000, 12:4500, 13:5000, 14:5500, 15:6000 ns. `pos_out` first takes the new level at the (N+1)-th edge after the trigger edge.
- R5: With `blank_mode` = 2'b00, `blank_trig` has no effect, and `pos_out` follows the inputs with the R2 latency.
- R6: During the window, `pos_out` holds its value, and a comparator edge that occurs inside the window never sets a flag. A trigger inside an open window restarts the full window.
- R7: A rising edge of a channel's polarity-adjusted level sets `irq_flag[i]` when `rise_ie[i]` is 1. A falling edge sets it when `fall_ie[i]` is 1. An edge whose enable is 0 leaves the flag unchanged.
- R8: A 1 on `flag_clr[i]` for one cycle clears `irq_flag[i]`. If a new edge sets the flag in the same cycle, the flag stays set.
- R9: `irq` is 1 exactly when at least one `irq_flag` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw | input | NCH | Raw asynchronous comparator outputs |
| pol_inv | input | NCH | Per-channel polarity, 1 = active low |
| pos_sel | input | 2 | Position routing select |
| pos_hold | input | 1 | Freeze position output |
| blank_trig | input | 1 | Blanking window start pulse |
| blank_mode | input | 2 | 2'b00 disables blanking |
| blank_code | input | 4 | Blanking duration code |
| rise_ie | input | NCH | Rising-edge flag enables |
| fall_ie | input | NCH | Falling-edge flag enables |
| flag_clr | input | NCH | Write-1-to-clear strobes for the flags |
| pos_out | output | 1 | Qualified position signal |
| chan_stat | output | NCH | Real-time polarity-adjusted levels |
| irq_flag | output | NCH | Latched edge flags |
| irq | output | 1 | OR of all flags |

## Verification
The assertions check four rules on every cycle:
- the position output holds while the hold input is set;
- the position output holds while the internal blanking window is open;
- the position output is driven low when no channel is selected;
- no flag rises without an enable, or while the window is open.

Only the scenarios in the bench can show:
- the exact window length for each duration code;
- the restart of the window on a retrigger;
- the two-edge synchronizer latency;
- set-over-clear priority.

// File: rtl/zcq_pkg.sv
package zcq_pkg;

    localparam int unsigned MAX_BLANK_NS = 6000;

    // Non-linear duration table, computed from three linear segments.
    function automatic int unsigned blank_ns(input logic [3:0] code);
        int unsigned c;
        c = int'(code);
        if (c == 0)      return 100;
        else if (c < 4)  return 250 * c;
        else if (c < 7)  return 1000 + 250 * (c - 4);
        else             return 2000 + 500 * (c - 7);
    endfunction

    function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned per_ns);
        return (ns + per_ns - 1) / per_ns;
    endfunction

endpackage

// File: rtl/zcq_sync.sv
module zcq_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d_async;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign d_sync = pipe_q[STAGES-1];
endmodule

// File: rtl/zcq_blank_timer.sv
module zcq_blank_timer
    import zcq_pkg::*;
#(
    parameter int unsigned CLK_NS = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig,
    input  logic [1:0] mode,
    input  logic [3:0] code,
    output logic       active
);
    localparam int unsigned MAX_CYC = ns_to_cycles(MAX_BLANK_NS, CLK_NS);
    localparam int          CW      = $clog2(MAX_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;
    logic enabled;

    assign enabled = (mode != 2'b00);

    always_comb begin
        st_d = st_q;
        if (trig && enabled) begin
            st_d.cnt = CW'(ns_to_cycles(blank_ns(code), CLK_NS));
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = enabled && (st_q.cnt != '0);
endmodule

// File: rtl/zcq_edge_flags.sv
module zcq_edge_flags #(
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] lvl,
    input  logic           blocked,
    input  logic [NCH-1:0] rise_ie,
    input  logic [NCH-1:0] fall_ie,
    input  logic [NCH-1:0] clr,
    output logic [NCH-1:0] flags
);
    typedef struct packed {
        logic [NCH-1:0] prev;
        logic [NCH-1:0] flg;
    } edge_t;

    edge_t st_d, st_q;
    logic [NCH-1:0] hit;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic rise, fall;
        assign rise   = lvl[i] & ~st_q.prev[i];
        assign fall   = ~lvl[i] & st_q.prev[i];
        assign hit[i] = ~blocked & ((rise & rise_ie[i]) | (fall & fall_ie[i]));
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
        st_d.flg  = (st_q.flg & ~clr) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flg;
endmodule

// File: rtl/zc_blank_qual.sv
module zc_blank_qual #(
    parameter int          NCH         = 3,
    parameter int          SYNC_STAGES = 2,
    parameter int unsigned CLK_NS      = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] cmp_raw,
    input  logic [NCH-1:0] pol_inv,
    input  logic [1:0]     pos_sel,
    input  logic           pos_hold,
    input  logic           blank_trig,
    input  logic [1:0]     blank_mode,
    input  logic [3:0]     blank_code,
    input  logic [NCH-1:0] rise_ie,
    input  logic [NCH-1:0] fall_ie,
    input  logic [NCH-1:0] flag_clr,
    output logic           pos_out,
    output logic [NCH-1:0] chan_stat,
    output logic [NCH-1:0] irq_flag,
    output logic           irq
);
    typedef struct packed {
        logic pos;
    } top_t;

    logic [NCH-1:0] cmp_s;
    logic [NCH-1:0] lvl;
    logic           blank_act;
    logic           sel_lvl;
    top_t           st_d, st_q;

    zcq_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cmp_raw),
        .d_sync  (cmp_s)
    );

    assign lvl = cmp_s ^ pol_inv;

    zcq_blank_timer #(.CLK_NS(CLK_NS)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (blank_trig),
        .mode   (blank_mode),
        .code   (blank_code),
        .active (blank_act)
    );

    zcq_edge_flags #(.NCH(NCH)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl     (lvl),
        .blocked (blank_act),
        .rise_ie (rise_ie),
        .fall_ie (fall_ie),
        .clr     (flag_clr),
        .flags   (irq_flag)
    );

    always_comb begin
        case (pos_sel)
            2'b01:   sel_lvl = lvl[0];
            2'b10:   sel_lvl = (NCH > 1) ? lvl[1 % NCH] : 1'b0;
            2'b11:   sel_lvl = (NCH > 2) ? lvl[2 % NCH] : 1'b0;
            default: sel_lvl = 1'b0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (!pos_hold && !blank_act) begin
            st_d.pos = sel_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pos_out   = st_q.pos;
    assign chan_stat = lvl;
    assign irq       = |irq_flag;
endmodule

// File: rtl/zcq_checks.sv
module zcq_checks #(
    parameter int NCH = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           pos_hold,
    input logic [1:0]     pos_sel,
    input logic           pos_out,
    input logic           blank_act,
    input logic [NCH-1:0] irq_flag,
    input logic [NCH-1:0] rise_ie,
    input logic [NCH-1:0] fall_ie
);
    a_r3_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        pos_hold |=> $stable(pos_out));

    a_r6_blank_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        blank_act |=> $stable(pos_out));

    a_r2_unrouted_low: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_sel == 2'b00 && !pos_hold && !blank_act) |=> !pos_out);

    a_r6_no_flag_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
        blank_act |=> ((irq_flag & ~$past(irq_flag)) == '0));

    a_r7_flag_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_flag & ~$past(irq_flag) & ~$past(rise_ie | fall_ie)) == '0));
endmodule

bind zc_blank_qual zcq_checks #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pos_hold  (pos_hold),
    .pos_sel   (pos_sel),
    .pos_out   (pos_out),
    .blank_act (blank_act),
    .irq_flag  (irq_flag),
    .rise_ie   (rise_ie),
    .fall_ie   (fall_ie)
);

// File: tb/sim_zc_blank_qual.sv
module sim_zc_blank_qual;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmp_raw = '0, pol_inv = '0, rise_ie = '0, fall_ie = '0, flag_clr = '0;
    logic [1:0] pos_sel = '0, blank_mode = '0;
    logic       pos_hold = 1'b0, blank_trig = 1'b0;
    logic [3:0] blank_code = '0;
    logic       pos_out, irq;
    logic [2:0] chan_stat, irq_flag;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    zc_blank_qual #(.NCH(3), .SYNC_STAGES(2), .CLK_NS(10)) u0 (
        .clk, .rst_n, .cmp_raw, .pol_inv, .pos_sel, .pos_hold, .blank_trig,
        .blank_mode, .blank_code, .rise_ie, .fall_ie, .flag_clr,
        .pos_out, .chan_stat, .irq_flag, .irq
    );

    // {raw[2:0], pol[2:0], sel[1:0], exp_stat[2:0], exp_pos}
    localparam logic [11:0] VEC [9] = '{
        {3'b000, 3'b000, 2'b01, 3'b000, 1'b0},
        {3'b001, 3'b000, 2'b01, 3'b001, 1'b1},
        {3'b010, 3'b000, 2'b10, 3'b010, 1'b1},
        {3'b100, 3'b000, 2'b11, 3'b100, 1'b1},
        {3'b100, 3'b000, 2'b00, 3'b100, 1'b0},
        {3'b000, 3'b111, 2'b10, 3'b111, 1'b1},
        {3'b101, 3'b010, 2'b11, 3'b111, 1'b1},
        {3'b011, 3'b110, 2'b01, 3'b101, 1'b1},
        {3'b011, 3'b110, 2'b10, 3'b101, 1'b0}
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_cycles(input int code);
        int ns;
        case (code)
            0: ns = 100;   1: ns = 250;   2: ns = 500;   3: ns = 750;
            4: ns = 1000;  5: ns = 1250;  6: ns = 1500;  7: ns = 2000;
            8: ns = 2500;  9: ns = 3000;  10: ns = 3500; 11: ns = 4000;
            12: ns = 4500; 13: ns = 5000; 14: ns = 5500; default: ns = 6000;
        endcase
        return (ns + 9) / 10;
    endfunction

    task automatic clear_flags();
        flag_clr = 3'b111; step(1); flag_clr = '0;
    endtask

    // ch0 starts low, routed to pos; rising edge comes with the trigger
    task automatic blank_run(input int code, input bit retrig, input string req);
        int n;
        n = exp_cycles(code);
        blank_code = 4'(code);
        blank_trig = 1'b1; cmp_raw[0] = 1'b1;
        step(1); blank_trig = 1'b0;
        if (retrig) begin
            step(5);
            blank_trig = 1'b1; step(1); blank_trig = 1'b0;
        end
        step(n);
        chk({req, " pos held to end of window"}, pos_out, 0);
        step(1);
        chk({req, " pos released after window"}, pos_out, 1);
        chk("R6 edge in window sets no flag", irq_flag, 0);
        cmp_raw[0] = 1'b0; step(4);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        step(3);
        chk("R2 reset pos", pos_out, 0);
        chk("R8 reset flags", irq_flag, 0);
        chk("R9 reset irq", irq, 0);
        rst_n = 1'b1;
        step(2);
        chk("R1 reset stat", chan_stat, 0);

        // R1, R2: vector walk
        foreach (VEC[k]) begin
            cmp_raw = VEC[k][11:9]; pol_inv = VEC[k][8:6]; pos_sel = VEC[k][5:4];
            step(2);
            chk("R1 stat after two edges", chan_stat, VEC[k][3:1]);
            step(1);
            chk("R2 pos routing", pos_out, VEC[k][0]);
        end
        cmp_raw = '0; pol_inv = '0; pos_sel = 2'b01; step(4);

        // R2 latency: pos one edge after stat
        cmp_raw[0] = 1'b1; step(2);
        chk("R2 pos not yet updated", pos_out, 0);
        step(1);
        chk("R2 pos updated", pos_out, 1);

        // R3 hold
        pos_hold = 1'b1; cmp_raw[0] = 1'b0; step(5);
        chk("R3 pos frozen by hold", pos_out, 1);
        pos_hold = 1'b0; step(1);
        chk("R3 pos follows after hold", pos_out, 0);

        // R7 edge enables
        rise_ie = 3'b001; fall_ie = 3'b010;
        cmp_raw[0] = 1'b1; step(3);
        chk("R7 rising ch0 sets flag", irq_flag, 3'b001);
        chk("R9 irq with flag", irq, 1);
        cmp_raw[1] = 1'b1; step(3);
        chk("R7 disabled rising ch1 ignored", irq_flag, 3'b001);
        cmp_raw[1] = 1'b0; step(3);
        chk("R7 falling ch1 sets flag", irq_flag, 3'b011);
        cmp_raw[2] = 1'b1; step(3); cmp_raw[2] = 1'b0; step(3);
        chk("R7 ch2 without enables ignored", irq_flag, 3'b011);

        // R8 clear and priority
        flag_clr = 3'b001; step(1); flag_clr = '0;
        chk("R8 clear ch0 only", irq_flag, 3'b010);
        chk("R9 irq with one flag", irq, 1);
        flag_clr = 3'b010; step(1); flag_clr = '0;
        chk("R8 clear ch1", irq_flag, 3'b000);
        chk("R9 irq low", irq, 0);
        cmp_raw[0] = 1'b0; step(3);
        cmp_raw[0] = 1'b1; step(2);
        flag_clr = 3'b001; step(1); flag_clr = '0;
        chk("R8 set wins over clear", irq_flag, 3'b001);
        clear_flags();
        cmp_raw[0] = 1'b0; fall_ie = '0; step(4); clear_flags();

        // R4, R6 blanking windows
        blank_mode = 2'b01;
        blank_run(0, 1'b0, "R4 code0");
        clear_flags();
        blank_run(7, 1'b0, "R4 code7");
        clear_flags();
        blank_run(15, 1'b0, "R4 code15");
        clear_flags();
        blank_run(0, 1'b1, "R6 retrigger");
        clear_flags();

        // R5 disabled mode
        blank_mode = 2'b00; blank_code = 4'd15;
        blank_trig = 1'b1; cmp_raw[0] = 1'b1; step(1); blank_trig = 1'b0;
        step(2);
        chk("R5 trigger ignored, pos follows", pos_out, 1);
        chk("R5 edge flagged without blanking", irq_flag, 3'b001);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule